// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block is the address glue between a 68000-style processor bus and its memories and peripherals. The bus has a 24-bit byte address space, presented here as a 23-bit word address, a 16-bit data path, and separate strobes for the upper and lower byte. On every strobed access the block picks one target: RAM, ROM, or one of two 8-bit peripheral register files. It drives a chip select and an index for that target and steers the read data back to the processor.

A boot overlay flag chooses between two low-memory maps. The flag is set when reset ends, so ROM answers at address zero and the processor can fetch its reset vectors from ROM. Software then clears the flag through one bit of an external port value, and RAM moves down to address zero. In the upper half of the address space the peripherals are found by masking the address against a fixed pattern. Any access at or near the top of the space, and every interrupt-acknowledge cycle, raises a peripheral-bus indication so that the processor runs a synchronous cycle and takes an autovector.

Write enables reach the memories and peripherals one clock after the access. For RAM this gives a read-modify-write path: a single-byte write is merged with the stored word read in the same cycle as the strobe.

Top module: `ovl_bus_decoder`

## Requirements
- R1: While reset is active and in the first cycle after it ends, `overlay_on` is 1 and `ram_we`, `pa_we` and `pb_we` are 0.
- R2: With the overlay set, word addresses below 0x300000 (byte addresses below 0x600000) select ROM for reads, so ROM appears at byte 0x000000 and again at byte 0x400000. Word addresses from 0x300000 up to 0x3FFFFF select RAM.
- R3: With the overlay clear, word addresses below 0x200000 (byte 0x000000 to 0x3FFFFF) select RAM, and word addresses 0x200000 to 0x2FFFFF select ROM for reads.
- R4: In a cycle with `port_load` high, `overlay_on` takes bit 4 of `port_val` from the next cycle on (1 = overlay map). In any other cycle it holds its value.
- R5: A write that decodes to ROM asserts no select and causes no write enable. With the overlay clear, an access to ROM space at word address 0x300000 or above asserts no select and reads 0x0000.
- R6: `ram_idx` is the low 16 bits of the word address and `rom_idx` is the low 15 bits, so accesses wrap modulo 64K words and 32K words.
- R7: `periph_bus` is 1 exactly when `strobe` is high and either the word address is at least 0x700000 (byte 0xE00000) or `iack` is high.
- R8: A data access at word address 0x400000 or above selects register file A when (address AND 0x78F000) equals 0x70F000, and register file B when it equals 0x68F000. `per_idx` is word-address bits 11:8.
- R9: A peripheral read returns the register byte on `rdata[7:0]`. `rdata[15:8]` is 0xFF when both byte strobes are high and 0x00 otherwise.
- R10: A read at or above word address 0x400000 that selects neither register file returns 0x00 on the low byte, with the high byte filled as in R9. `rdata` is 0x0000 for writes and for cycles with no selected target.
- R11: A RAM write raises `ram_we` for one cycle in the next cycle, with `ram_widx` set to the word index. `ram_wdata` takes each lane whose strobe was high from `wdata` and the other lane from `ram_rdata` (upper lane = bits 15:8 = `uds`).
- R12: A peripheral write raises `pa_we` or `pb_we` in the next cycle, with `per_widx` set to the register index and `per_wdata` set to `wdata[7:0]`.
- R13: A strobed cycle with `iack` high asserts no select and causes no write enable. Only the autovector indication on `periph_bus` is raised.
- R14: A data access needs `strobe` and at least one byte strobe. Without a byte strobe nothing is selected and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_w | input | 23 | Word address (byte address bits 23:1) |
| strobe | input | 1 | Address strobe, access in progress |
| rd | input | 1 | 1 = read, 0 = write |
| uds | input | 1 | Upper byte strobe (data bits 15:8) |
| lds | input | 1 | Lower byte strobe (data bits 7:0) |
| iack | input | 1 | Interrupt-acknowledge cycle |
| wdata | input | 16 | Write data from the processor |
| rdata | output | 16 | Read data to the processor |
| periph_bus | output | 1 | Synchronous peripheral cycle / autovector request |
| port_val | input | 8 | External port value; bit 4 is the overlay request |
| port_load | input | 1 | Load the overlay flag from `port_val` |
| overlay_on | output | 1 | Current overlay flag |
| ram_cs | output | 1 | RAM select (reads and writes) |
| ram_idx | output | 16 | RAM word index |
| ram_rdata | input | 16 | RAM word at `ram_idx` |
| ram_we | output | 1 | Registered RAM write enable |
| ram_widx | output | 16 | Registered RAM write index |
| ram_wdata | output | 16 | Registered merged RAM write word |
| rom_cs | output | 1 | ROM select (reads only) |
| rom_idx | output | 15 | ROM word index |
| rom_rdata | input | 16 | ROM word at `rom_idx` |
| pa_cs | output | 1 | Register file A select |
| pb_cs | output | 1 | Register file B select |
| per_idx | output | 4 | Peripheral register index |
| per_rdata_a | input | 8 | Register file A read byte |
| per_rdata_b | input | 8 | Register file B read byte |
| pa_we | output | 1 | Registered write enable, file A |
| pb_we | output | 1 | Registered write enable, file B |
| per_widx | output | 4 | Registered peripheral write index |
| per_wdata | output | 8 | Registered peripheral write byte |

## Verification
The bench builds the block with its default parameters: a 23-bit word address, 64K-word RAM and 32K-word ROM indexes, and a 4-bit register index at word bit 8. These values match the map fixed by the requirements, so the bench can reach every region boundary directly: the ROM mirror at byte 0x400000, the RAM start at 0x600000 under the overlay, the dead ROM tail, both select patterns and the 0xE00000 peripheral-bus threshold. The small index widths also let the bench reach wrap-around with addresses only one bit above each memory size.

// File: rtl/ovl_pkg.sv
// Shared types for the boot-overlay address decoder.
// Assumes: one decoded target per bus cycle.
package ovl_pkg;
    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_RAM   = 3'd1,
        RG_ROM   = 3'd2,
        RG_PA    = 3'd3,
        RG_PB    = 3'd4,
        RG_IOGAP = 3'd5
    } region_e;
endpackage

// File: rtl/ovl_flag_reg.sv
// Boot overlay flag. It is set by reset and reloaded from one bit of an external port value.
// Assumes: port_load is a single-cycle qualifier, synchronous to clk.
module ovl_flag_reg #(
    parameter int PORT_W  = 8,
    parameter int OVL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_val,
    input  logic              port_load,
    output logic              overlay_on
);
    logic unused_port;
    assign unused_port = ^port_val;

    // Hold the overlay flag; reset selects the overlay map.
    always_ff @(posedge clk) begin
        if (!rst_n)         overlay_on <= 1'b1;
        else if (port_load) overlay_on <= port_val[OVL_BIT];
    end
endmodule

// File: rtl/ovl_region_decode.sv
// Combinational region decode: it picks the target of the current bus cycle and flags peripheral-bus cycles.
// Assumes: the address is stable while strobe is high.
module ovl_region_decode
    import ovl_pkg::*;
#(
    parameter int              ADDR_W   = 23,
    parameter logic [ADDR_W-1:0] IO_BASE  = 23'h400000,
    parameter logic [ADDR_W-1:0] VPA_BASE = 23'h700000,
    parameter logic [ADDR_W-1:0] HI_RAM   = 23'h300000,
    parameter logic [ADDR_W-1:0] LO_TOP   = 23'h200000,
    parameter logic [ADDR_W-1:0] SEL_MASK = 23'h78F000,
    parameter logic [ADDR_W-1:0] SEL_A    = 23'h70F000,
    parameter logic [ADDR_W-1:0] SEL_B    = 23'h68F000
) (
    input  logic [ADDR_W-1:0] addr_w,
    input  logic              strobe,
    input  logic              uds,
    input  logic              lds,
    input  logic              rd,
    input  logic              iack,
    input  logic              overlay_on,
    output region_e           region,
    output logic              periph_bus
);
    logic data_act;
    logic ram_hit;

    // Choose the target region and the peripheral-bus indication.
    always_comb begin
        data_act   = strobe && (uds || lds);
        periph_bus = strobe && (iack || (addr_w >= VPA_BASE));
        ram_hit    = overlay_on ? (addr_w >= HI_RAM) : (addr_w < LO_TOP);
        region     = RG_NONE;
        if (data_act && !iack) begin
            if (addr_w >= IO_BASE) begin
                if ((addr_w & SEL_MASK) == SEL_A)      region = RG_PA;
                else if ((addr_w & SEL_MASK) == SEL_B) region = RG_PB;
                else                                   region = RG_IOGAP;
            end else if (ram_hit) begin
                region = RG_RAM;
            end else if (rd && (addr_w < HI_RAM)) begin
                region = RG_ROM;
            end
        end
    end
endmodule

// File: rtl/ovl_write_stage.sv
// Registered write stage: it merges byte lanes into RAM words and delays every write enable by one cycle.
// Assumes: ram_old is the stored word at the accessed index in the cycle of the access.
module ovl_write_stage
    import ovl_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RAM_AW  = 16,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 8,
    parameter int ADDR_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic              rd,
    input  logic              uds,
    input  logic              lds,
    input  logic [ADDR_W-1:0] addr_w,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ram_old,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_widx,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              pa_we,
    output logic              pb_we,
    output logic [IDX_W-1:0]  per_widx,
    output logic [DATA_W/2-1:0] per_wdata
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] merged;

    // Take each strobed lane from the processor and keep the other lane from the stored word.
    always_comb begin
        merged[DATA_W-1:LANE_W] = uds ? wdata[DATA_W-1:LANE_W] : ram_old[DATA_W-1:LANE_W];
        merged[LANE_W-1:0]      = lds ? wdata[LANE_W-1:0]      : ram_old[LANE_W-1:0];
    end

    // Register the write enables and their payload for the cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            pa_we     <= 1'b0;
            pb_we     <= 1'b0;
            ram_widx  <= '0;
            ram_wdata <= '0;
            per_widx  <= '0;
            per_wdata <= '0;
        end else begin
            ram_we <= (region == RG_RAM) && !rd;
            pa_we  <= (region == RG_PA)  && !rd;
            pb_we  <= (region == RG_PB)  && !rd;
            if (!rd) begin
                ram_widx  <= addr_w[RAM_AW-1:0];
                ram_wdata <= merged;
                per_widx  <= addr_w[IDX_LSB +: IDX_W];
                per_wdata <= wdata[LANE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ovl_bus_decoder.sv
// Top of the boot-overlay address decoder: region decode, overlay flag, read steering and registered writes.
// Assumes: memories and register files return read data in the cycle their select is high.
module ovl_bus_decoder
    import ovl_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int DATA_W  = 16,
    parameter int RAM_AW  = 16,
    parameter int ROM_AW  = 15,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 8,
    parameter int PORT_W  = 8,
    parameter int OVL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_w,
    input  logic              strobe,
    input  logic              rd,
    input  logic              uds,
    input  logic              lds,
    input  logic              iack,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              periph_bus,
    input  logic [PORT_W-1:0] port_val,
    input  logic              port_load,
    output logic              overlay_on,
    output logic              ram_cs,
    output logic [RAM_AW-1:0] ram_idx,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_widx,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_idx,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              pa_cs,
    output logic              pb_cs,
    output logic [IDX_W-1:0]  per_idx,
    input  logic [DATA_W/2-1:0] per_rdata_a,
    input  logic [DATA_W/2-1:0] per_rdata_b,
    output logic              pa_we,
    output logic              pb_we,
    output logic [IDX_W-1:0]  per_widx,
    output logic [DATA_W/2-1:0] per_wdata
);
    localparam int LANE_W = DATA_W / 2;

    region_e           region;
    logic [LANE_W-1:0] fill_hi;

    ovl_flag_reg #(.PORT_W(PORT_W), .OVL_BIT(OVL_BIT)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_val   (port_val),
        .port_load  (port_load),
        .overlay_on (overlay_on)
    );

    ovl_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_w     (addr_w),
        .strobe     (strobe),
        .uds        (uds),
        .lds        (lds),
        .rd         (rd),
        .iack       (iack),
        .overlay_on (overlay_on),
        .region     (region),
        .periph_bus (periph_bus)
    );

    ovl_write_stage #(
        .DATA_W(DATA_W), .RAM_AW(RAM_AW), .IDX_W(IDX_W),
        .IDX_LSB(IDX_LSB), .ADDR_W(ADDR_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .rd        (rd),
        .uds       (uds),
        .lds       (lds),
        .addr_w    (addr_w),
        .wdata     (wdata),
        .ram_old   (ram_rdata),
        .ram_we    (ram_we),
        .ram_widx  (ram_widx),
        .ram_wdata (ram_wdata),
        .pa_we     (pa_we),
        .pb_we     (pb_we),
        .per_widx  (per_widx),
        .per_wdata (per_wdata)
    );

    // Drive the target selects and the indexes (the indexes wrap at each memory size).
    always_comb begin
        ram_cs  = (region == RG_RAM);
        rom_cs  = (region == RG_ROM);
        pa_cs   = (region == RG_PA);
        pb_cs   = (region == RG_PB);
        ram_idx = addr_w[RAM_AW-1:0];
        rom_idx = addr_w[ROM_AW-1:0];
        per_idx = addr_w[IDX_LSB +: IDX_W];
    end

    // Steer read data: full words from memory; from I/O, a byte on the low lane with the high lane filled.
    always_comb begin
        fill_hi = (uds && lds) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
        rdata   = '0;
        if (rd) begin
            case (region)
                RG_RAM:   rdata = ram_rdata;
                RG_ROM:   rdata = rom_rdata;
                RG_PA:    rdata = {fill_hi, per_rdata_a};
                RG_PB:    rdata = {fill_hi, per_rdata_b};
                RG_IOGAP: rdata = {fill_hi, {LANE_W{1'b0}}};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ovl_bus_decoder_chk.sv
// Checker for the boot-overlay address decoder. It observes ports only and is bound to the top.
module ovl_bus_decoder_chk #(
    parameter int              ADDR_W   = 23,
    parameter logic [ADDR_W-1:0] VPA_BASE = 23'h700000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_w,
    input logic              strobe,
    input logic              rd,
    input logic              iack,
    input logic              periph_bus,
    input logic              port_load,
    input logic              overlay_on,
    input logic              ram_cs,
    input logic              rom_cs,
    input logic              pa_cs,
    input logic              pb_cs,
    input logic              ram_we,
    input logic              pa_we,
    input logic              pb_we
);
    a_r7_high_space_vpa: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && addr_w >= VPA_BASE) |-> periph_bus);

    a_r13_iack_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && iack) |-> (periph_bus && !ram_cs && !rom_cs && !pa_cs && !pb_cs));

    a_r5_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> rd);

    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_cs, pa_cs, pb_cs}));

    a_r11_ram_we_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(ram_cs && !rd));

    a_r12_per_we_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_we || pb_we) |-> $past((pa_cs || pb_cs) && !rd));

    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(port_load) |-> $stable(overlay_on));
endmodule

bind ovl_bus_decoder ovl_bus_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ovl_bus_decoder_bench.sv
// Scoreboard bench: the driver pushes expected results, and the monitor compares them away from the clock edge.
module ovl_bus_decoder_bench;
    localparam int CLK_P = 10;

    typedef struct {
        logic [3:0]  cs;      // {ram, rom, pa, pb}
        logic [15:0] idx;
        logic [15:0] rdata;
        logic        vpa;
        logic        ovl;
        logic        ram_we;
        logic [15:0] ram_widx;
        logic [15:0] ram_wdata;
        logic        pa_we;
        logic        pb_we;
        logic [3:0]  per_widx;
        logic [7:0]  per_wdata;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [22:0] addr_w = '0;
    logic        strobe = 0, rd = 1, uds = 0, lds = 0, iack = 0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        periph_bus;
    logic [7:0]  port_val = '0;
    logic        port_load = 0;
    logic        overlay_on;
    logic        ram_cs, rom_cs, pa_cs, pb_cs;
    logic [15:0] ram_idx, ram_rdata, ram_widx, ram_wdata, rom_rdata;
    logic [14:0] rom_idx;
    logic        ram_we, pa_we, pb_we;
    logic [3:0]  per_idx, per_widx;
    logic [7:0]  per_rdata_a, per_rdata_b, per_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t exp_q[$];

    logic        m_ovl = 1;
    logic        p_ram_we = 0, p_pa_we = 0, p_pb_we = 0;
    logic [15:0] p_ram_widx = 0, p_ram_wdata = 0;
    logic [3:0]  p_per_widx = 0;
    logic [7:0]  p_per_wdata = 0;

    always #(CLK_P/2) clk = ~clk;

    // Memory and register-file stand-ins with fixed, index-derived contents.
    assign ram_rdata   = ram_idx ^ 16'hA5C3;
    assign rom_rdata   = {1'b1, rom_idx};
    assign per_rdata_a = {4'hA, per_idx};
    assign per_rdata_b = {4'hB, per_idx};

    ovl_bus_decoder u_ovl_bus_decoder (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: apply one bus cycle, model the expected outputs, push them to the scoreboard.
    task automatic drive(input string tag, input logic s, input logic r, input logic u, input logic l,
                         input logic ia, input logic [22:0] a, input logic [15:0] wd,
                         input logic ld, input logic [7:0] pv);
        exp_t e;
        logic [7:0] hi;
        logic       act;
        @(negedge clk);
        strobe = s; rd = r; uds = u; lds = l; iack = ia; addr_w = a; wdata = wd;
        port_load = ld; port_val = pv;
        e.tag = tag; e.cs = 4'b0; e.idx = 16'h0; e.rdata = 16'h0;
        e.vpa = s && (ia || a >= 23'h700000);
        e.ovl = m_ovl;
        e.ram_we = p_ram_we; e.ram_widx = p_ram_widx; e.ram_wdata = p_ram_wdata;
        e.pa_we = p_pa_we; e.pb_we = p_pb_we; e.per_widx = p_per_widx; e.per_wdata = p_per_wdata;
        p_ram_we = 0; p_pa_we = 0; p_pb_we = 0;
        hi  = (u && l) ? 8'hFF : 8'h00;
        act = s && (u || l) && !ia;
        if (act) begin
            if (a >= 23'h400000) begin
                if ((a & 23'h78F000) == 23'h70F000) begin
                    e.cs = 4'b0010; e.idx = {12'h0, a[11:8]};
                    if (r) e.rdata = {hi, 4'hA, a[11:8]};
                    else begin p_pa_we = 1; p_per_widx = a[11:8]; p_per_wdata = wd[7:0]; end
                end else if ((a & 23'h78F000) == 23'h68F000) begin
                    e.cs = 4'b0001; e.idx = {12'h0, a[11:8]};
                    if (r) e.rdata = {hi, 4'hB, a[11:8]};
                    else begin p_pb_we = 1; p_per_widx = a[11:8]; p_per_wdata = wd[7:0]; end
                end else if (r) e.rdata = {hi, 8'h00};
            end else if (m_ovl ? (a >= 23'h300000) : (a < 23'h200000)) begin
                e.cs = 4'b1000; e.idx = a[15:0];
                if (r) e.rdata = a[15:0] ^ 16'hA5C3;
                else begin
                    p_ram_we = 1; p_ram_widx = a[15:0];
                    p_ram_wdata = {u ? wd[15:8] : (a[15:8] ^ 8'hA5), l ? wd[7:0] : (a[7:0] ^ 8'hC3)};
                end
            end else if (r && a < 23'h300000) begin
                e.cs = 4'b0100; e.idx = {1'b0, a[14:0]};
                e.rdata = {1'b1, a[14:0]};
            end
        end
        exp_q.push_back(e);
        if (ld) m_ovl = pv[4];
    endtask

    // Monitor: compare the outputs against the oldest expected item, a quarter period after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [15:0] aidx;
                e = exp_q.pop_front();
                aidx = ram_cs ? ram_idx : rom_cs ? {1'b0, rom_idx} : (pa_cs || pb_cs) ? {12'h0, per_idx} : 16'h0;
                chk({e.tag, " select"}, {28'h0, ram_cs, rom_cs, pa_cs, pb_cs}, {28'h0, e.cs});
                if (e.cs != 0) chk({e.tag, " index"}, {16'h0, aidx}, {16'h0, e.idx});
                chk({e.tag, " rdata"}, {16'h0, rdata}, {16'h0, e.rdata});
                chk({e.tag, " periph_bus"}, {31'h0, periph_bus}, {31'h0, e.vpa});
                chk({e.tag, " overlay"}, {31'h0, overlay_on}, {31'h0, e.ovl});
                chk({e.tag, " write enables"}, {29'h0, ram_we, pa_we, pb_we}, {29'h0, e.ram_we, e.pa_we, e.pb_we});
                if (e.ram_we) chk({e.tag, " ram write"}, {ram_widx, ram_wdata}, {e.ram_widx, e.ram_wdata});
                if (e.pa_we || e.pb_we) chk({e.tag, " per write"}, {20'h0, per_widx, per_wdata}, {20'h0, e.per_widx, e.per_wdata});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk("R1 reset overlay", {31'h0, overlay_on}, 32'h1);
        chk("R1 reset we", {29'h0, ram_we, pa_we, pb_we}, 32'h0);
        @(negedge clk);
        rst_n = 1;
        drive("R1 idle after reset",  0,1,0,0,0, 23'h000000, 16'h0, 0, 8'h0);
        drive("R2 rom at zero",       1,1,1,1,0, 23'h000010, 16'h0, 0, 8'h0);
        drive("R2 rom mirror",        1,1,1,1,0, 23'h200123, 16'h0, 0, 8'h0);
        drive("R2 ram high",          1,1,1,1,0, 23'h300005, 16'h0, 0, 8'h0);
        drive("R6 rom wrap",          1,1,1,1,0, 23'h008010, 16'h0, 0, 8'h0);
        drive("R5 rom write dropped", 1,0,1,1,0, 23'h000020, 16'h1234, 0, 8'h0);
        drive("R5 after rom write",   0,1,0,0,0, 23'h000000, 16'h0, 0, 8'h0);
        drive("R8 R9 R7 file A word", 1,1,1,1,0, 23'h77F300, 16'h0, 0, 8'h0);
        drive("R8 R9 file B byte",    1,1,0,1,0, 23'h6FF500, 16'h0, 0, 8'h0);
        drive("R10 gap word",         1,1,1,1,0, 23'h500000, 16'h0, 0, 8'h0);
        drive("R10 R7 gap byte high", 1,1,1,0,0, 23'h780000, 16'h0, 0, 8'h0);
        drive("R4 clear overlay",     0,1,0,0,0, 23'h000000, 16'h0, 1, 8'h00);
        drive("R4 load bit4 zero",    0,1,0,0,0, 23'h000000, 16'h0, 1, 8'hEF);
        drive("R3 ram at zero",       1,1,1,1,0, 23'h000040, 16'h0, 0, 8'h0);
        drive("R3 R6 rom normal",     1,1,1,1,0, 23'h210000, 16'h0, 0, 8'h0);
        drive("R6 ram wrap",          1,1,1,1,0, 23'h1F0007, 16'h0, 0, 8'h0);
        drive("R5 dead rom tail",     1,1,1,1,0, 23'h300000, 16'h0, 0, 8'h0);
        drive("R11 word write",       1,0,1,1,0, 23'h000123, 16'hBEEF, 0, 8'h0);
        drive("R11 upper byte write", 1,0,1,0,0, 23'h000456, 16'h12FF, 0, 8'h0);
        drive("R11 lower byte write", 1,0,0,1,0, 23'h010789, 16'hEE34, 0, 8'h0);
        drive("R12 file A write",     1,0,0,1,0, 23'h77F200, 16'h00C7, 0, 8'h0);
        drive("R12 file B write",     1,0,1,1,0, 23'h68FF00, 16'h995A, 0, 8'h0);
        drive("R13 iack",             1,1,1,1,1, 23'h7FFFFF, 16'h0, 0, 8'h0);
        drive("R13 iack write",       1,0,1,1,1, 23'h000010, 16'h5555, 0, 8'h0);
        drive("R14 no byte strobe",   1,0,0,0,0, 23'h000010, 16'h5555, 0, 8'h0);
        drive("R4 set overlay",       0,1,0,0,0, 23'h000000, 16'h0, 1, 8'h10);
        drive("R2 rom again",         1,1,1,1,0, 23'h000000, 16'h0, 0, 8'h0);
        drive("R7 idle",              0,1,0,0,0, 23'h7FFFFF, 16'h0, 0, 8'h0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule